// File: doc/BRIEF.md
# Sync-Aligned Transparent Serial Channel

This block moves unframed character data over a single bit-serial line in each direction, one bit per rising edge of the bit clock. After a direction is enabled it stays idle until a synchronization event arrives. Only then does it start counting character periods. The transmitter holds the line at logic 1 while it waits. The receiver ignores its input line while it waits.

A mode input selects the synchronization source. In pin mode the source is a falling edge on an external sync line, which is sampled through a register chain. In slot mode the source is the first assigned slot pulse for that direction that follows a frame-sync pulse, so the two directions can align at different moments even when they are enabled together.

Characters travel least significant bit first. Their length is set per character, from 1 to 16 bits. Transmit characters are taken through a valid/ready port at character boundaries. Received characters are presented with a single-cycle strobe. A hunt command drops the receiver back into the waiting state.

Top module: `sersync_chan`

## Requirements
- R1: While reset is applied and in the first cycle after it, txd is 1, tx_ready is 0 and rx_valid is 0.
- R2: An enabled transmitter that has not yet been synchronized drives txd to 1 and keeps tx_ready at 0.
- R3: In pin mode (mode_slot = 0), the sync event is a high-to-low change of sync_in. If sync_in is first sampled low at clock edge k, an enabled, unsynchronized direction becomes synchronized at edge k+2. From then on tx_ready is high in the next bit time, and the receiver samples its first data bit at edge k+3.
- R4: tx_ready is high exactly in the last bit time of each transmit character period, and in the first bit time after synchronization. If tx_valid is also high at that edge, tx_data is loaded and sent least significant bit first over the next char_len bit times.
- R5: If no character is offered at a boundary, the transmitter sends a full period of 1s, char_len bit times long, and tx_ready stays low until the last bit time of that period.
- R6: After synchronization the receiver assembles char_len bits, least significant bit first, back to back. One cycle after the edge that samples the last bit, it drives rx_valid high for one cycle. rx_data then holds the character, with every bit above char_len at 0.
- R7: Each direction synchronizes on the first event after its own enable. Later events do not re-align a direction that is already synchronized.
- R8: When both directions are enabled together in pin mode, one falling edge of sync_in synchronizes both of them.
- R9: Dropping an enable returns that direction to the unsynchronized state. The transmitter shows txd = 1 and tx_ready = 0 from the next cycle. The receiver raises no rx_valid until a new event.
- R10: A hunt pulse returns the receiver to the unsynchronized state and discards any partly received character. No rx_valid follows until a new sync event.
- R11: In slot mode (mode_slot = 1), sync_in is ignored. A frame_sync pulse arms both directions. A direction synchronizes at the edge that samples the first tx_slot or rx_slot pulse of its own after arming. A slot pulse with no earlier frame_sync has no effect.
- R12: char_len (1 to 16) is taken at the start of each character period in each direction. A new value takes effect from the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; one bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_slot | input | 1 | 0: sync on sync_in falling edge; 1: sync on slot after frame sync |
| sync_in | input | 1 | External sync line (pin mode) |
| frame_sync | input | 1 | Frame start pulse (slot mode) |
| tx_slot | input | 1 | Transmit slot pulse (slot mode) |
| rx_slot | input | 1 | Receive slot pulse (slot mode) |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| hunt | input | 1 | Receiver re-hunt command pulse |
| char_len | input | 5 | Character length in bits, 1 to 16 |
| tx_data | input | 16 | Transmit character, right aligned |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmit character accepted at this edge if valid |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 16 | Received character, right aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
The properties assume that the inputs change only between clock edges. They also assume that hunt and the enables are plain levels or pulses that do not depend on the outputs in the same cycle. The bench meets this by driving every input on the falling clock edge. It keeps char_len constant inside any character whose contents it checks, and changes the length only while both directions are idle. Slot and frame pulses are always one cycle wide, and a slot pulse is never sent in the same cycle as a frame pulse.

// File: rtl/sersync_pkg.sv
package sersync_pkg;

   typedef enum logic {
      SYNC_PIN  = 1'b0,
      SYNC_SLOT = 1'b1
   } sync_mode_e;

   typedef struct packed {
      logic rx;
      logic tx;
   } dir_evt_t;

endpackage

// File: rtl/sersync_event.sv
module sersync_event
   import sersync_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  sync_mode_e mode,
   input  logic       sync_in,
   input  logic       frame_sync,
   input  logic       tx_slot,
   input  logic       rx_slot,
   output dir_evt_t   evt
);

   // sampler chain for the external sync line
   logic [STAGES-1:0] smp_q;
   logic              smp_prev_q;
   logic              pin_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q      <= '1;
         smp_prev_q <= 1'b1;
      end else begin
         smp_q      <= {smp_q[STAGES-2:0], sync_in};
         smp_prev_q <= smp_q[STAGES-1];
      end
   end

   assign pin_fall = smp_prev_q & ~smp_q[STAGES-1];

   // per-direction arming for slot mode
   logic [1:0] slot_v;
   logic [1:0] hit;

   assign slot_v = {rx_slot, tx_slot};

   for (genvar d = 0; d < 2; d++) begin : g_dir
      logic armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b0;
         end else if (frame_sync) begin
            armed_q <= 1'b1;
         end else if (slot_v[d]) begin
            armed_q <= 1'b0;
         end
      end

      assign hit[d] = (mode == SYNC_SLOT) ? (armed_q & slot_v[d]) : pin_fall;
   end

   assign evt.tx = hit[0];
   assign evt.rx = hit[1];

endmodule

// File: rtl/sersync_tx.sv
module sersync_tx #(
   parameter int MAX_LEN = 16,
   parameter int LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               evt,
   input  logic [LEN_W-1:0]   len_eff,
   input  logic [MAX_LEN-1:0] data,
   input  logic               valid,
   output logic               ready,
   output logic               txd
);

   logic               synced_q;
   logic [LEN_W-1:0]   cnt_q;
   logic [MAX_LEN-1:0] sh_q;

   assign ready = synced_q & (cnt_q == '0);
   assign txd   = sh_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '1;
      end else if (!en) begin
         synced_q <= 1'b0;
         cnt_q    <= '0;
         sh_q     <= '1;
      end else if (!synced_q) begin
         synced_q <= evt;
         cnt_q    <= '0;
         sh_q     <= '1;
      end else if (cnt_q == '0) begin
         // character boundary: load a character or a period of ones
         cnt_q <= len_eff - 1'b1;
         sh_q  <= valid ? data : '1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
         sh_q  <= {1'b1, sh_q[MAX_LEN-1:1]};
      end
   end

endmodule

// File: rtl/sersync_rx.sv
module sersync_rx #(
   parameter int MAX_LEN = 16,
   parameter int LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               evt,
   input  logic               hunt,
   input  logic [LEN_W-1:0]   len_eff,
   input  logic               rxd,
   output logic [MAX_LEN-1:0] data,
   output logic               valid
);

   logic               synced_q;
   logic [LEN_W-1:0]   cnt_q;
   logic [LEN_W-1:0]   cur_len_q;
   logic [MAX_LEN-1:0] sh_q;
   logic [MAX_LEN-1:0] nxt;
   logic [LEN_W-1:0]   align;

   assign nxt   = {rxd, sh_q[MAX_LEN-1:1]};
   assign align = LEN_W'(MAX_LEN) - cur_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_q  <= 1'b0;
         cnt_q     <= '0;
         cur_len_q <= '0;
         sh_q      <= '0;
         data      <= '0;
         valid     <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (!en || hunt) begin
            synced_q <= 1'b0;
            cnt_q    <= '0;
         end else if (!synced_q) begin
            if (evt) begin
               synced_q  <= 1'b1;
               cnt_q     <= len_eff - 1'b1;
               cur_len_q <= len_eff;
            end
         end else begin
            sh_q <= nxt;
            if (cnt_q == '0) begin
               valid     <= 1'b1;
               data      <= nxt >> align;
               cnt_q     <= len_eff - 1'b1;
               cur_len_q <= len_eff;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sersync_chan.sv
module sersync_chan
   import sersync_pkg::*;
#(
   parameter int MAX_LEN     = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W      = $clog2(MAX_LEN + 1)
) (
   input  logic               bit_clk,
   input  logic               rst_n,
   input  logic               mode_slot,
   input  logic               sync_in,
   input  logic               frame_sync,
   input  logic               tx_slot,
   input  logic               rx_slot,
   input  logic               tx_en,
   input  logic               rx_en,
   input  logic               hunt,
   input  logic [LEN_W-1:0]   char_len,
   input  logic [MAX_LEN-1:0] tx_data,
   input  logic               tx_valid,
   output logic               tx_ready,
   output logic               txd,
   input  logic               rxd,
   output logic [MAX_LEN-1:0] rx_data,
   output logic               rx_valid
);

   if (MAX_LEN < 2 || MAX_LEN > 32) begin : g_bad_len
      $error("sersync_chan: MAX_LEN must lie in 2..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("sersync_chan: SYNC_STAGES must be at least 2");
   end

   logic [LEN_W-1:0] len_eff;
   dir_evt_t         evt;

   assign len_eff = (char_len == '0 || char_len > LEN_W'(MAX_LEN))
                    ? LEN_W'(MAX_LEN) : char_len;

   sersync_event #(
      .STAGES (SYNC_STAGES)
   ) u_evt (
      .clk        (bit_clk),
      .rst_n      (rst_n),
      .mode       (sync_mode_e'(mode_slot)),
      .sync_in    (sync_in),
      .frame_sync (frame_sync),
      .tx_slot    (tx_slot),
      .rx_slot    (rx_slot),
      .evt        (evt)
   );

   sersync_tx #(
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W)
   ) u_tx (
      .clk     (bit_clk),
      .rst_n   (rst_n),
      .en      (tx_en),
      .evt     (evt.tx),
      .len_eff (len_eff),
      .data    (tx_data),
      .valid   (tx_valid),
      .ready   (tx_ready),
      .txd     (txd)
   );

   sersync_rx #(
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W)
   ) u_rx (
      .clk     (bit_clk),
      .rst_n   (rst_n),
      .en      (rx_en),
      .evt     (evt.rx),
      .hunt    (hunt),
      .len_eff (len_eff),
      .rxd     (rxd),
      .data    (rx_data),
      .valid   (rx_valid)
   );

endmodule

// File: rtl/sersync_chan_chk.sv
module sersync_chan_chk (
   input logic bit_clk,
   input logic rst_n,
   input logic tx_en,
   input logic tx_valid,
   input logic tx_lsb,
   input logic tx_ready,
   input logic txd,
   input logic rx_en,
   input logic hunt,
   input logic rx_valid
);

   // R2: tx_ready only follows a cycle in which the transmitter was enabled
   p_ready_en_r2 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      tx_ready |-> $past(tx_en));

   // R4: an accepted character shows its least significant bit first
   p_lsb_first_r4 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      (tx_en && tx_ready && tx_valid) |=> (txd == $past(tx_lsb)));

   // R9: a disabled transmitter idles high and offers no handshake
   p_tx_off_r9 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      !tx_en |=> (txd && !tx_ready));

   // R9: a disabled receiver raises no strobe
   p_rx_off_r9 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      !rx_en |=> !rx_valid);

   // R10: hunt discards the character in progress
   p_hunt_drop_r10 : assert property (@(posedge bit_clk) disable iff (!rst_n)
      hunt |=> !rx_valid);

endmodule

bind sersync_chan sersync_chan_chk u_chk (
   .bit_clk  (bit_clk),
   .rst_n    (rst_n),
   .tx_en    (tx_en),
   .tx_valid (tx_valid),
   .tx_lsb   (tx_data[0]),
   .tx_ready (tx_ready),
   .txd      (txd),
   .rx_en    (rx_en),
   .hunt     (hunt),
   .rx_valid (rx_valid)
);

// File: tb/sim_sersync_chan.sv
`timescale 1ns/1ps
module sim_sersync_chan;

   logic        bit_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_slot = 1'b0;
   logic        sync_in = 1'b1;
   logic        frame_sync = 1'b0;
   logic        tx_slot = 1'b0;
   logic        rx_slot = 1'b0;
   logic        tx_en = 1'b0;
   logic        rx_en = 1'b0;
   logic        hunt = 1'b0;
   logic [4:0]  char_len = 5'd5;
   logic [15:0] tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_ready;
   logic        txd;
   logic        rxd = 1'b1;
   logic [15:0] rx_data;
   logic        rx_valid;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q[$];

   always #5 bit_clk = ~bit_clk;

   sersync_chan u0 (
      .bit_clk(bit_clk), .rst_n(rst_n), .mode_slot(mode_slot), .sync_in(sync_in),
      .frame_sync(frame_sync), .tx_slot(tx_slot), .rx_slot(rx_slot),
      .tx_en(tx_en), .rx_en(rx_en), .hunt(hunt), .char_len(char_len),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
      .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic nb(input int n);
      repeat (n) @(negedge bit_clk);
   endtask

   // driver: pushes the expected character, then drives its bits
   task automatic send_rx(input logic [15:0] d, input int n, input bit wiggle);
      exp_q.push_back(d);
      for (int i = 0; i < n; i++) begin
         rxd = d[i];
         if (wiggle && i == 0) sync_in = 1'b1;
         if (wiggle && i == 2) sync_in = 1'b0;
         nb(1);
      end
   endtask

   task automatic tx_bits(input string req, input logic [15:0] d, input int n);
      for (int i = 0; i < n; i++) begin
         chk(req, {31'd0, txd}, {31'd0, d[i]});
         if (i < n - 1) nb(1);
      end
   endtask

   // monitor: compares each received strobe with the scoreboard
   always @(negedge bit_clk) begin
      if (rst_n && rx_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R6/R10: actual=unexpected rx_valid data=%0h expected=no strobe", rx_data);
         end else begin
            automatic logic [15:0] e = exp_q.pop_front();
            if (rx_data !== e) begin
               errors++;
               $display("FAIL R6: actual=%0h expected=%0h", rx_data, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge bit_clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      nb(3);
      // R1: reset state
      chk("R1 txd", {31'd0, txd}, 32'd1);
      chk("R1 tx_ready", {31'd0, tx_ready}, 32'd0);
      chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
      rst_n = 1'b1;
      nb(1);
      chk("R1 txd after", {31'd0, txd}, 32'd1);

      // R2: enabled, no sync yet
      tx_en = 1'b1; tx_valid = 1'b1; tx_data = 16'h0016;
      nb(6);
      chk("R2 txd", {31'd0, txd}, 32'd1);
      chk("R2 tx_ready", {31'd0, tx_ready}, 32'd0);

      // R3/R4/R5: pin sync, first character, empty period, second character
      sync_in = 1'b0;
      nb(3);
      chk("R3 tx_ready", {31'd0, tx_ready}, 32'd1);
      chk("R3 txd idle", {31'd0, txd}, 32'd1);
      nb(1);
      tx_bits("R4 bits", 16'h0016, 5);
      chk("R4 boundary ready", {31'd0, tx_ready}, 32'd1);
      tx_valid = 1'b0;
      nb(1);
      sync_in = 1'b1;
      for (int i = 0; i < 4; i++) begin
         chk("R5 ones", {31'd0, txd}, 32'd1);
         chk("R5 ready low", {31'd0, tx_ready}, 32'd0);
         nb(1);
      end
      chk("R5 last ones", {31'd0, txd}, 32'd1);
      chk("R5 ready at end", {31'd0, tx_ready}, 32'd1);
      tx_data = 16'h000A; tx_valid = 1'b1;
      nb(1);
      tx_valid = 1'b0;
      tx_bits("R5 late char", 16'h000A, 5);

      // R7: receiver enabled later, needs its own edge; extra edge ignored
      rx_en = 1'b1;
      for (int i = 0; i < 8; i++) begin
         rxd = i[0];
         nb(1);
      end
      sync_in = 1'b0;
      nb(3);
      send_rx(16'h0013, 5, 1'b0);
      send_rx(16'h000C, 5, 1'b1);   // R7: sync edge in mid character
      send_rx(16'h0005, 5, 1'b0);

      // R10: hunt in mid character
      rxd = 1'b0; nb(1);
      rxd = 1'b1; nb(1);
      hunt = 1'b1; nb(1);
      hunt = 1'b0; sync_in = 1'b1;
      for (int i = 0; i < 10; i++) begin
         rxd = i[1];
         nb(1);
      end
      chk("R10 no strobe after hunt", {31'd0, rx_valid}, 32'd0);
      sync_in = 1'b0;
      nb(3);
      send_rx(16'h0011, 5, 1'b0);

      // R9: disable both directions
      rx_en = 1'b0; tx_en = 1'b0;
      nb(1);
      chk("R9 txd", {31'd0, txd}, 32'd1);
      chk("R9 tx_ready", {31'd0, tx_ready}, 32'd0);
      nb(2);

      // R8/R12: enable together, one edge, new length 7
      char_len = 5'd7;
      tx_en = 1'b1; rx_en = 1'b1; tx_valid = 1'b1; tx_data = 16'h0015;
      sync_in = 1'b1;
      nb(2);
      chk("R9 unsynced after re-enable", {31'd0, tx_ready}, 32'd0);
      chk("R9 txd after re-enable", {31'd0, txd}, 32'd1);
      sync_in = 1'b0;
      nb(3);
      chk("R8 tx_ready", {31'd0, tx_ready}, 32'd1);
      fork
         send_rx(16'h004B, 7, 1'b0);
         begin
            nb(1);
            tx_valid = 1'b0;
            tx_bits("R8 R12 tx bits", 16'h0015, 7);
         end
      join
      rx_en = 1'b0; tx_en = 1'b0;
      nb(2);

      // R11: slot mode, 16-bit characters
      mode_slot = 1'b1; char_len = 5'd16;
      tx_en = 1'b1; rx_en = 1'b1; tx_valid = 1'b1; tx_data = 16'hA5C3;
      sync_in = 1'b1; nb(2);
      sync_in = 1'b0; nb(4);
      chk("R11 pin edge ignored", {31'd0, tx_ready}, 32'd0);
      tx_slot = 1'b1; rx_slot = 1'b1; nb(1);
      tx_slot = 1'b0; rx_slot = 1'b0; nb(3);
      chk("R11 slot without frame", {31'd0, tx_ready}, 32'd0);
      frame_sync = 1'b1; nb(1);
      frame_sync = 1'b0; rx_slot = 1'b1; nb(1);
      rx_slot = 1'b0;
      chk("R11 tx still waiting", {31'd0, tx_ready}, 32'd0);
      fork
         send_rx(16'h9E37, 16, 1'b0);
         begin
            nb(1);
            tx_slot = 1'b1; nb(1);
            tx_slot = 1'b0;
            chk("R11 tx_ready", {31'd0, tx_ready}, 32'd1);
            nb(1);
            tx_valid = 1'b0;
            tx_bits("R11 tx bits", 16'hA5C3, 16);
         end
      join
      rx_en = 1'b0; tx_en = 1'b0;
      nb(3);
      chk("R6 all characters seen", exp_q.size(), 32'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule